// File: doc/BRIEF.md
# Dual-Space I2C Target

This block is an I2C target that samples the bus with a system clock and opens two independent byte-addressed spaces to a bus controller. The first is a memory/configuration space. Its writes are collected in a 16-byte page staging buffer, and the buffer is copied into the storage array only when the transaction closes with a Stop. The second is a command/status space. Writes to it take effect as each byte is acknowledged.

The target answers to two device-type codes, one for each space. The memory type can be moved to an alternate code so that the block can share a bus with other memory parts. A three-bit bus address qualifies each code. Two of its bits come from configuration inputs. The top bit comes from a pin or is a fixed zero. On the bus, the block only pulls SDA low through a drive-enable output. A monitor-halt flag tells the surrounding logic that the block is busy with a transaction, and a one-cycle commit pulse carries the page base and a byte mask for the nonvolatile update.

Top module: `i2c_dual_space_target`

## Requirements
- R1: SCL and SDA are synchronized to the system clock. A Start is SDA falling while SCL is high, and a Stop is SDA rising while SCL is high. After reset, SDA is not driven, monitor_halt_o is low and commit_o is low.
- R2: The memory space answers to device type 1010b when cfg_alt_type_i is 0, and to 1011b when it is 1. The device type is bits [7:4] of the address byte, and bit 0 of that byte is 1 for a read.
- R3: The command/status space always answers to device type 1001b, whatever cfg_alt_type_i is set to.
- R4: Address-byte bits [2:1] must equal cfg_ba_i. Bit [3] must equal a2_i when cfg_a2_sel_i is 1, and must be 0 when cfg_a2_sel_i is 0.
- R5: An address byte that does not match is not acknowledged. Every later byte is then ignored, and is also not acknowledged, until the next Start or Stop.
- R6: A write consists of the address byte, a pointer byte and then data bytes, and the target acknowledges each of them. Command-space data is stored at once, and the pointer advances by one after each byte.
- R7: Memory-space write data goes to the staging buffer. Only the low 4 bits of the pointer advance, and they wrap from 15 to 0 inside the same 16-byte page.
- R8: A Stop with staged bytes present starts a commit. One cycle later, commit_o pulses for exactly one cycle, with commit_page_o holding the page base (low 4 bits zero) and commit_be_o holding one bit per staged byte. A Start clears the staging buffer, so a write that ends in a repeated Start commits nothing.
- R9: A write that carries only a pointer, followed by a repeated Start and a read address, makes the read begin at that pointer. Each controller-acknowledged byte advances the pointer by one.
- R10: Read bytes are shifted out MSB first. After the controller does not acknowledge (NACK), the target releases SDA.
- R11: monitor_halt_o rises when a matching address byte is acknowledged. It stays high across repeated Starts and falls only after a Stop.
- R12: While commit_busy_i is high, the memory device type is not acknowledged, but the command device type still is.
- R13: The target changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| a2_i | input | 1 | Pin value for bus-address bit 2 |
| cfg_alt_type_i | input | 1 | Select the alternate memory device type 1011b |
| cfg_ba_i | input | 2 | Bus-address bits [1:0] |
| cfg_a2_sel_i | input | 1 | Take bus-address bit 2 from a2_i instead of 0 |
| commit_busy_i | input | 1 | Nonvolatile update in progress |
| monitor_halt_o | output | 1 | Transaction in progress, from address acknowledge to Stop |
| commit_o | output | 1 | One-cycle request to commit the staged page |
| commit_page_o | output | 8 | Byte address of the committed page base |
| commit_be_o | output | 16 | Mask of the staged bytes in the page |

## Verification
If the pointer is wrong, the very next read byte returns a neighbour's value. If the page-wrap logic is wrong, the commit mask and the later read-back disagree with the expected page contents within one transaction. If a decode or busy gate is wrong, the ninth clock of the address byte carries the wrong acknowledge level, so the error is visible one bit time after the address. If the staging buffer keeps data past a repeated Start, an extra commit pulse appears one cycle after the next Stop.

// File: rtl/i2c_dst_pkg.sv
package i2c_dst_pkg;
  localparam int PTR_W      = 8;
  localparam int PAGE_BYTES = 16;
  localparam logic [3:0] TYPE_MEM     = 4'b1010;
  localparam logic [3:0] TYPE_MEM_ALT = 4'b1011;
  localparam logic [3:0] TYPE_CMD     = 4'b1001;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_PTR, ST_PTR_ACK,
    ST_WDATA, ST_WDATA_ACK, ST_RDATA, ST_RACK
  } state_e;

  typedef enum logic {SP_MEM, SP_CMD} space_e;
endpackage

// File: rtl/i2c_dst_sync.sv
module i2c_dst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_o      = scl_ff[STAGES-1];
  assign sda_o      = sda_ff[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/i2c_dst_mem.sv
module i2c_dst_mem import i2c_dst_pkg::*; #(
  parameter int MEM_AW = 6
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_i,
  input  logic                    stage_we_i,
  input  logic [3:0]              stage_idx_i,
  input  logic [7:0]              stage_data_i,
  input  logic [MEM_AW-5:0]       page_i,
  input  logic                    commit_i,
  input  logic [MEM_AW-1:0]       rd_addr_i,
  output logic [7:0]              rd_data_o,
  output logic [PAGE_BYTES-1:0]   be_o
);
  localparam int DEPTH = 1 << MEM_AW;

  logic [7:0]            mem_q   [DEPTH];
  logic [7:0]            stage_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] be_q;
  logic [MEM_AW-5:0]     page_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      for (int i = 0; i < PAGE_BYTES; i++) stage_q[i] <= '0;
      be_q   <= '0;
      page_q <= '0;
    end else if (commit_i) begin
      for (int i = 0; i < PAGE_BYTES; i++)
        if (be_q[i]) mem_q[{page_q, 4'(i)}] <= stage_q[i];
      be_q <= '0;
    end else if (clr_i) begin
      be_q <= '0;
    end else if (stage_we_i) begin
      stage_q[stage_idx_i] <= stage_data_i;
      be_q[stage_idx_i]    <= 1'b1;
      page_q               <= page_i;
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
  assign be_o      = be_q;
endmodule

// File: rtl/i2c_dst_cmd.sv
module i2c_dst_cmd #(
  parameter int CMD_AW = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CMD_AW-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic [CMD_AW-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o
);
  localparam int DEPTH = 1 << CMD_AW;
  logic [7:0] regs_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) regs_q[i] <= '0;
    end else if (we_i) begin
      regs_q[wr_addr_i] <= wr_data_i;
    end
  end

  assign rd_data_o = regs_q[rd_addr_i];
endmodule

// File: rtl/i2c_dual_space_target.sv
module i2c_dual_space_target import i2c_dst_pkg::*; #(
  parameter int MEM_AW      = 6,
  parameter int CMD_AW      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe_o,
  input  logic        a2_i,
  input  logic        cfg_alt_type_i,
  input  logic [1:0]  cfg_ba_i,
  input  logic        cfg_a2_sel_i,
  input  logic        commit_busy_i,
  output logic        monitor_halt_o,
  output logic        commit_o,
  output logic [7:0]  commit_page_o,
  output logic [15:0] commit_be_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;

  state_e            state_q;
  space_e            space_q;
  logic [3:0]        cnt_q;
  logic [7:0]        sh_q;
  logic [PTR_W-1:0]  ptr_q, rd_ptr;
  logic              rw_q, oe_q, halt_q, rack_q;
  logic              commit_q;
  logic [7:0]        commit_page_q;
  logic [PAGE_BYTES-1:0] commit_be_q, stage_be;
  logic [7:0]        mem_rd, cmd_rd, rd_byte;
  logic [3:0]        mem_type;
  logic              ba_ok, match_mem, match_cmd, byte_done, wr_byte;
  logic              stage_we, cmd_we, commit_req, shifting;

  i2c_dst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_ev), .stop_o(stop_ev)
  );

  assign mem_type  = cfg_alt_type_i ? TYPE_MEM_ALT : TYPE_MEM;
  assign ba_ok     = sh_q[3:1] == {cfg_a2_sel_i & a2_i, cfg_ba_i};
  assign match_mem = ba_ok && sh_q[7:4] == mem_type && !commit_busy_i;
  assign match_cmd = ba_ok && sh_q[7:4] == TYPE_CMD;
  assign byte_done = scl_fall && cnt_q == 4'd8;
  assign wr_byte   = state_q == ST_WDATA && byte_done;
  assign stage_we  = wr_byte && space_q == SP_MEM;
  assign cmd_we    = wr_byte && space_q == SP_CMD;
  assign rd_ptr    = (state_q == ST_RACK) ? ptr_q + PTR_W'(1) : ptr_q;
  assign rd_byte   = (space_q == SP_MEM) ? mem_rd : cmd_rd;
  assign commit_req = stop_ev && |stage_be;
  assign shifting  = state_q inside {ST_ADDR, ST_PTR, ST_WDATA};

  i2c_dst_mem #(.MEM_AW(MEM_AW)) u_mem (
    .clk_i, .rst_ni,
    .clr_i(start_ev), .stage_we_i(stage_we), .stage_idx_i(ptr_q[3:0]),
    .stage_data_i(sh_q), .page_i(ptr_q[MEM_AW-1:4]), .commit_i(commit_req),
    .rd_addr_i(rd_ptr[MEM_AW-1:0]), .rd_data_o(mem_rd), .be_o(stage_be)
  );

  i2c_dst_cmd #(.CMD_AW(CMD_AW)) u_cmd (
    .clk_i, .rst_ni,
    .we_i(cmd_we), .wr_addr_i(ptr_q[CMD_AW-1:0]), .wr_data_i(sh_q),
    .rd_addr_i(rd_ptr[CMD_AW-1:0]), .rd_data_o(cmd_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      space_q <= SP_MEM;
      cnt_q   <= '0;
      sh_q    <= '0;
      ptr_q   <= '0;
      rw_q    <= 1'b0;
      oe_q    <= 1'b0;
      halt_q  <= 1'b0;
      rack_q  <= 1'b1;
    end else if (stop_ev) begin
      state_q <= ST_IDLE;
      oe_q    <= 1'b0;
      halt_q  <= 1'b0;
    end else if (start_ev) begin
      state_q <= ST_ADDR;
      cnt_q   <= '0;
      oe_q    <= 1'b0;
    end else if (scl_rise) begin
      if (shifting && cnt_q != 4'd8) begin
        sh_q  <= {sh_q[6:0], sda_s};
        cnt_q <= cnt_q + 4'd1;
      end
      if (state_q == ST_RACK) rack_q <= sda_s;
    end else if (scl_fall) begin
      unique case (state_q)
        ST_ADDR: if (byte_done) begin
          if (match_mem || match_cmd) begin
            state_q <= ST_ADDR_ACK;
            space_q <= match_cmd ? SP_CMD : SP_MEM;
            rw_q    <= sh_q[0];
            oe_q    <= 1'b1;
            halt_q  <= 1'b1;
          end else begin
            state_q <= ST_IDLE;
          end
        end
        ST_ADDR_ACK: begin
          cnt_q <= '0;
          if (rw_q) begin
            state_q <= ST_RDATA;
            sh_q    <= rd_byte;
            oe_q    <= ~rd_byte[7];
          end else begin
            state_q <= ST_PTR;
            oe_q    <= 1'b0;
          end
        end
        ST_PTR: if (byte_done) begin
          ptr_q   <= sh_q;
          oe_q    <= 1'b1;
          state_q <= ST_PTR_ACK;
        end
        ST_WDATA: if (byte_done) begin
          oe_q    <= 1'b1;
          state_q <= ST_WDATA_ACK;
          // memory pointer wraps inside its page
          ptr_q   <= (space_q == SP_MEM) ? {ptr_q[PTR_W-1:4], ptr_q[3:0] + 4'd1}
                                         : ptr_q + PTR_W'(1);
        end
        ST_PTR_ACK, ST_WDATA_ACK: begin
          oe_q    <= 1'b0;
          cnt_q   <= '0;
          state_q <= ST_WDATA;
        end
        ST_RDATA: begin
          if (cnt_q == 4'd7) begin
            oe_q    <= 1'b0;
            state_q <= ST_RACK;
          end else begin
            sh_q  <= {sh_q[6:0], 1'b0};
            oe_q  <= ~sh_q[6];
            cnt_q <= cnt_q + 4'd1;
          end
        end
        ST_RACK: begin
          if (!rack_q) begin
            ptr_q   <= rd_ptr;
            sh_q    <= rd_byte;
            oe_q    <= ~rd_byte[7];
            cnt_q   <= '0;
            state_q <= ST_RDATA;
          end else begin
            state_q <= ST_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      commit_q      <= 1'b0;
      commit_page_q <= '0;
      commit_be_q   <= '0;
    end else begin
      commit_q <= commit_req;
      if (commit_req) begin
        commit_page_q <= {ptr_q[PTR_W-1:4], 4'b0};
        commit_be_q   <= stage_be;
      end
    end
  end

  assign sda_oe_o       = oe_q;
  assign monitor_halt_o = halt_q;
  assign commit_o       = commit_q;
  assign commit_page_o  = commit_page_q;
  assign commit_be_o    = commit_be_q;
endmodule

// File: rtl/i2c_dst_checker.sv
module i2c_dst_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        scl_s,
  input logic        stop_ev,
  input logic        sda_oe_o,
  input logic        monitor_halt_o,
  input logic        commit_o,
  input logic [7:0]  commit_page_o,
  input logic [15:0] commit_be_o
);
  a_r11_halt_ends_on_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(monitor_halt_o) |-> $past(stop_ev));

  a_r8_commit_follows_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> $past(stop_ev));

  a_r8_commit_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> !commit_o);

  a_r8_commit_mask_nonempty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> commit_be_o != 16'h0);

  a_r7_commit_page_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> commit_page_o[3:0] == 4'h0);

  a_r13_drive_only_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !scl_s);
endmodule

bind i2c_dual_space_target i2c_dst_checker u_dst_checker (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .scl_s          (scl_s),
  .stop_ev        (stop_ev),
  .sda_oe_o       (sda_oe_o),
  .monitor_halt_o (monitor_halt_o),
  .commit_o       (commit_o),
  .commit_page_o  (commit_page_o),
  .commit_be_o    (commit_be_o)
);

// File: tb/i2c_dual_space_target_bench.sv
module i2c_dual_space_target_bench;
  localparam int Q = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1;
  logic a2 = 1'b1, cfg_alt = 1'b0, cfg_a2_sel = 1'b1, busy = 1'b0;
  logic [1:0] cfg_ba = 2'b01;
  logic sda_oe, halt, commit;
  logic [7:0] commit_page;
  logic [15:0] commit_be;
  wire sda_bus = sda_m & ~sda_oe;

  int nvec = 0, nfail = 0, ncommit = 0;
  logic [7:0] last_page;
  logic [15:0] last_be;
  logic quiet = 1'b0;
  logic [7:0] mem_m [64];
  logic [7:0] cmd_m [16];

  always #5 clk = ~clk;

  i2c_dual_space_target u_i2c_dual_space_target (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe_o(sda_oe),
    .a2_i(a2), .cfg_alt_type_i(cfg_alt), .cfg_ba_i(cfg_ba), .cfg_a2_sel_i(cfg_a2_sel),
    .commit_busy_i(busy), .monitor_halt_o(halt), .commit_o(commit),
    .commit_page_o(commit_page), .commit_be_o(commit_be)
  );

  always @(negedge clk) begin
    if (commit) begin
      ncommit++;
      last_page = commit_page;
      last_be   = commit_be;
    end
    // R5: while an ignored transfer is in flight the target must never pull SDA
    if (quiet) begin
      nvec++;
      if (sda_oe) begin
        nfail++;
        $display("FAIL R5 sda driven while ignored act=1 exp=0");
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic bus_start();
    sda_m = 1'b1; scl = 1'b1; wq();
    sda_m = 1'b0; wq();
    scl = 1'b0; wq();
  endtask

  task automatic bus_rstart();
    sda_m = 1'b1; wq();
    scl = 1'b1; wq();
    sda_m = 1'b0; wq();
    scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq();
    scl = 1'b1; wq();
    sda_m = 1'b1; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq();
      scl = 1'b1; wq(); wq();
      scl = 1'b0;
    end
    sda_m = 1'b1; wq();
    scl = 1'b1; wq();
    acked = ~sda_bus; wq();
    scl = 1'b0; wq();
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      wq();
      scl = 1'b1; wq();
      b[i] = sda_bus; wq();
      scl = 1'b0;
    end
    wq();
    sda_m = ~give_ack; wq();
    scl = 1'b1; wq(); wq();
    scl = 1'b0; wq();
    sda_m = 1'b1;
  endtask

  // write one transaction and update the model as the requirements say
  task automatic write_txn(input logic [7:0] dev, input logic [7:0] ptr,
                           input logic [7:0] data [$], input string req);
    logic ack;
    logic [15:0] be_exp = '0;
    int c0 = ncommit;
    bit is_mem = dev[7:4] != 4'b1001;
    bus_start();
    send_byte(dev, ack);  chk({req, " address ack"}, ack, 1);
    send_byte(ptr, ack);  chk("R6 pointer ack", ack, 1);
    foreach (data[i]) begin
      send_byte(data[i], ack); chk("R6 data ack", ack, 1);
      if (is_mem) be_exp[(ptr + i) & 15] = 1'b1;
    end
    chk("R11 halt before stop", halt, 1);
    chk("R8 no commit before stop", ncommit, c0);
    bus_stop();
    chk("R11 halt cleared by stop", halt, 0);
    if (is_mem) begin
      foreach (data[i]) mem_m[((ptr & 8'hF0) | ((ptr + i) & 15)) & 63] = data[i];
      chk("R8 one commit after stop", ncommit, c0 + 1);
      chk("R8 commit page base", last_page, ptr & 8'hF0);
      chk("R7 commit byte mask", last_be, be_exp);
    end else begin
      foreach (data[i]) cmd_m[(ptr + i) & 15] = data[i];
      chk("R6 command write makes no commit", ncommit, c0);
    end
  endtask

  task automatic read_txn(input logic [7:0] dev, input logic [7:0] ptr, input int n);
    logic ack;
    logic [7:0] b, e;
    bit is_mem = dev[7:4] != 4'b1001;
    int c0 = ncommit;
    bus_start();
    send_byte(dev, ack);  chk("R9 dummy write address ack", ack, 1);
    send_byte(ptr, ack);  chk("R9 pointer ack", ack, 1);
    bus_rstart();
    chk("R11 halt kept over repeated start", halt, 1);
    send_byte(dev | 8'h01, ack); chk("R9 read address ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, b);
      e = is_mem ? mem_m[(ptr + i) & 63] : cmd_m[(ptr + i) & 15];
      chk("R9 R10 read data", b, e);
    end
    chk("R10 sda released after nack", sda_oe, 0);
    bus_stop();
    chk("R8 read makes no commit", ncommit, c0);
  endtask

  task automatic probe_nack(input logic [7:0] dev, input string req);
    logic ack;
    bus_start();
    quiet = 1'b1;
    send_byte(dev, ack);  chk({req, " address not acked"}, ack, 0);
    send_byte(8'h00, ack); chk("R5 follow-on byte ignored", ack, 0);
    chk("R11 no halt on mismatch", halt, 0);
    quiet = 1'b0;
    bus_stop();
  endtask

  task automatic probe_ack(input logic [7:0] dev, input string req);
    logic ack;
    bus_start();
    send_byte(dev, ack); chk({req, " address acked"}, ack, 1);
    bus_stop();
  endtask

  bit done = 0;

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    logic ack, c;
    logic [7:0] b;
    int c0;
    for (int i = 0; i < 64; i++) mem_m[i] = '0;
    for (int i = 0; i < 16; i++) cmd_m[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    wq();
    chk("R1 reset sda released", sda_oe, 0);
    chk("R1 reset halt low", halt, 0);
    chk("R1 reset commit low", commit, 0);

    // R2 R7: page write crossing the page end wraps to its start
    write_txn(8'hAA, 8'h1E, '{8'h11, 8'h22, 8'h33}, "R2");
    read_txn(8'hAA, 8'h1E, 3);
    read_txn(8'hAA, 8'h10, 2);

    // R3 R6: command space
    write_txn(8'h9A, 8'h03, '{8'hA5, 8'h5A}, "R3");
    read_txn(8'h9A, 8'h03, 2);

    // R8: data then repeated start, no commit
    c0 = ncommit;
    bus_start();
    send_byte(8'hAA, ack); send_byte(8'h30, ack); send_byte(8'h77, ack);
    chk("R6 staged byte acked", ack, 1);
    bus_rstart();
    send_byte(8'hAB, ack); chk("R9 read after write acked", ack, 1);
    recv_byte(1'b0, b);
    chk("R9 read at advanced pointer", b, mem_m[8'h31 & 63]);
    bus_stop();
    chk("R8 repeated start drops staging", ncommit, c0);
    read_txn(8'hAA, 8'h30, 1);

    // R4: bus address bits
    a2 = 1'b0;
    probe_nack(8'hAA, "R4 pin bit mismatch");
    probe_ack(8'hA2, "R4 pin bit zero");
    a2 = 1'b1; cfg_a2_sel = 1'b0;
    probe_nack(8'hAA, "R4 constant bit mismatch");
    probe_ack(8'hA2, "R4 constant zero");
    cfg_a2_sel = 1'b1;
    probe_nack(8'hA6, "R4 low bits mismatch");
    probe_nack(8'h5A, "R5 foreign type");

    // R2: alternate memory type
    cfg_alt = 1'b1;
    probe_nack(8'hAA, "R2 default type disabled");
    write_txn(8'hBA, 8'h05, '{8'h3C}, "R2");
    read_txn(8'hBA, 8'h04, 3);
    probe_ack(8'h9A, "R3 command type unaffected");

    // R12: busy blocks memory space only
    busy = 1'b1;
    probe_nack(8'hBA, "R12 busy");
    probe_ack(8'h9A, "R12 command while busy");
    busy = 1'b0;

    // R7: full 16-byte page starting mid-page
    write_txn(8'hBA, 8'h28, '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08,
                              8'h09, 8'h0A, 8'h0B, 8'h0C, 8'h0D, 8'h0E, 8'h0F, 8'h10}, "R7");
    read_txn(8'hBA, 8'h20, 16);
    read_txn(8'h9A, 8'h0F, 3);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule